// File: doc/BRIEF.md
# Accumulator Execution Unit with Condition Code

This block is the execute stage of a small 24-bit accumulator machine. On each strobe it receives:

- a 4-bit operation select;
- the current accumulator A, a memory operand word that has already been fetched, and the current 2-bit condition code;
- the linkage register L, the program counter and a jump target address.

One clock later it presents the updated accumulator, condition code, program counter and linkage register, together with a one-cycle result-valid pulse. Integers are two's complement. The block has no floating point.

All arithmetic writes its result back to A. A compare leaves A alone and sets only the three-valued condition code, which the conditional jumps then test. A subroutine call saves the return address in L, and a return jumps to the address held in L. There is no stack.

A two-state controller sequences the block:

- ST_IDLE means no result is pending.
- ST_RESULT marks the cycle in which fresh results are presented.

The controller has three transitions:

- IDLE→RESULT on a strobe.
- RESULT→RESULT on a back-to-back strobe.
- RESULT→IDLE when no strobe arrives.

Top module: `acc_exec_unit`

## Requirements
- R1: The outputs update only at the clock edge that samples `op_vld` high, and `res_valid` is high in exactly the cycle that follows such an edge. Without a strobe, every output holds its value and `res_valid` is 0.
- R2: ADD (code 0) writes A+operand and SUB (code 1) writes A−operand into A, both modulo 2^24. The condition code and L pass through from their inputs, and PC becomes PC+3.
- R3: MUL (code 2) writes the low 24 bits of the signed product of A and the operand into A.
- R4: DIV (code 3) with a nonzero operand writes the signed quotient, truncated toward zero, into A. The overflow case −2^23/−1 gives 0x800000.
- R5: DIV with a zero operand leaves A equal to `acc_in` and sets `div_err`. Every later strobe that is not a divide by zero clears `div_err`.
- R6: COMP (code 4) leaves A equal to `acc_in` and sets the condition code from a signed comparison of A with the operand: 2'b00 for less, 2'b01 for equal, 2'b10 for greater.
- R7: JLT (5), JEQ (6) and JGT (7) load the target into PC when `cc_in` is 00, 01 or 10 respectively. Otherwise PC becomes PC+3, with the sum wrapping at 2^ADDR_W.
- R8: JSUB (8) writes PC+3 (wrapping) into L and loads the target into PC.
- R9: RSUB (9) loads `lnk_in` into PC and leaves L equal to `lnk_in`.
- R10: After reset, A, PC and L are 0, the condition code is 2'b01, and `div_err` and `res_valid` are 0.
- R11: Codes 10 to 15 pass A, the condition code and L through unchanged, advance PC by 3 and clear `div_err`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_vld | input | 1 | Strobe: operands and operation are valid |
| op_code | input | 4 | Operation select |
| acc_in | input | DATA_W | Current accumulator |
| opnd_in | input | DATA_W | Fetched memory operand word |
| cc_in | input | 2 | Current condition code |
| lnk_in | input | ADDR_W | Current linkage register |
| pc_in | input | ADDR_W | Current program counter |
| tgt_in | input | ADDR_W | Jump target address |
| acc_q | output | DATA_W | New accumulator |
| cc_q | output | 2 | New condition code |
| pc_q | output | ADDR_W | Next program counter |
| lnk_q | output | ADDR_W | New linkage register |
| div_err | output | 1 | Divide-by-zero flag of the last operation |
| res_valid | output | 1 | Results presented this cycle |

## Verification
The bench builds the block with its defaults, DATA_W=24 and ADDR_W=20. This makes the real 24-bit signed corners reachable: the most negative word, the wrap of products and quotients, and signed comparisons across zero. The 20-bit address width lets a PC near 0xFFFFF show the PC+3 wrap on both the not-taken path and the return address saved by a call.

// File: rtl/acc_exec_pkg.sv
package acc_exec_pkg;

    typedef enum logic [3:0] {
        OP_ADD  = 4'd0,
        OP_SUB  = 4'd1,
        OP_MUL  = 4'd2,
        OP_DIV  = 4'd3,
        OP_COMP = 4'd4,
        OP_JLT  = 4'd5,
        OP_JEQ  = 4'd6,
        OP_JGT  = 4'd7,
        OP_JSUB = 4'd8,
        OP_RSUB = 4'd9
    } op_e;

    typedef enum logic [1:0] {
        CC_LT = 2'b00,
        CC_EQ = 2'b01,
        CC_GT = 2'b10
    } cc_e;

    typedef enum logic {
        ST_IDLE   = 1'b0,
        ST_RESULT = 1'b1
    } state_e;

endpackage

// File: rtl/acc_arith.sv
module acc_arith
    import acc_exec_pkg::*;
#(
    parameter int DATA_W = 24
) (
    input  op_e               op,
    input  logic [DATA_W-1:0] a,
    input  logic [DATA_W-1:0] b,
    output logic [DATA_W-1:0] res,
    output logic              div_zero
);

    localparam int PROD_W = 2 * DATA_W;
    localparam int N_OPND = 2;

    logic [DATA_W-1:0] opnd   [N_OPND];
    logic [DATA_W-1:0] mag    [N_OPND];
    logic              is_neg [N_OPND];

    assign opnd[0] = a;
    assign opnd[1] = b;

    // Sign and magnitude of each operand for the divider.
    for (genvar gi = 0; gi < N_OPND; gi++) begin : g_mag
        assign is_neg[gi] = opnd[gi][DATA_W-1];
        assign mag[gi]    = is_neg[gi] ? (~opnd[gi] + 1'b1) : opnd[gi];
    end

    logic [DATA_W-1:0]        sum_w;
    logic [DATA_W-1:0]        diff_w;
    logic signed [PROD_W-1:0] a_ext;
    logic signed [PROD_W-1:0] b_ext;
    logic signed [PROD_W-1:0] prod_w;
    logic                     b_is_zero;
    logic [DATA_W-1:0]        divisor;
    logic [DATA_W-1:0]        q_mag;
    logic [DATA_W-1:0]        quot_w;

    assign sum_w     = a + b;
    assign diff_w    = a - b;
    assign a_ext     = signed'({{DATA_W{a[DATA_W-1]}}, a});
    assign b_ext     = signed'({{DATA_W{b[DATA_W-1]}}, b});
    assign prod_w    = a_ext * b_ext;
    assign b_is_zero = (b == '0);
    assign divisor   = b_is_zero ? DATA_W'(1) : mag[1];
    assign q_mag     = mag[0] / divisor;
    assign quot_w    = (is_neg[0] ^ is_neg[1]) ? (~q_mag + 1'b1) : q_mag;

    always_comb begin
        res      = a;
        div_zero = 1'b0;
        unique case (op)
            OP_ADD: res = sum_w;
            OP_SUB: res = diff_w;
            OP_MUL: res = prod_w[DATA_W-1:0];
            OP_DIV: begin
                if (b_is_zero) begin
                    div_zero = 1'b1;
                end else begin
                    res = quot_w;
                end
            end
            default: res = a;
        endcase
    end

endmodule

// File: rtl/acc_compare.sv
module acc_compare
    import acc_exec_pkg::*;
#(
    parameter int DATA_W = 24
) (
    input  logic [DATA_W-1:0] a,
    input  logic [DATA_W-1:0] b,
    output cc_e               cc
);

    logic lt_w;
    logic eq_w;

    assign lt_w = ($signed(a) < $signed(b));
    assign eq_w = (a == b);

    always_comb begin
        if (eq_w) begin
            cc = CC_EQ;
        end else if (lt_w) begin
            cc = CC_LT;
        end else begin
            cc = CC_GT;
        end
    end

endmodule

// File: rtl/acc_pc_unit.sv
module acc_pc_unit
    import acc_exec_pkg::*;
#(
    parameter int ADDR_W = 20
) (
    input  op_e               op,
    input  logic [1:0]        cc_in,
    input  logic [ADDR_W-1:0] pc,
    input  logic [ADDR_W-1:0] tgt,
    input  logic [ADDR_W-1:0] lnk,
    output logic [ADDR_W-1:0] pc_n,
    output logic [ADDR_W-1:0] lnk_n
);

    localparam logic [ADDR_W-1:0] PC_STEP = ADDR_W'(3);

    logic [ADDR_W-1:0] pc_seq;
    logic              take;

    assign pc_seq = pc + PC_STEP;

    always_comb begin
        take = 1'b0;
        unique case (op)
            OP_JLT:  take = (cc_in == CC_LT);
            OP_JEQ:  take = (cc_in == CC_EQ);
            OP_JGT:  take = (cc_in == CC_GT);
            OP_JSUB: take = 1'b1;
            default: take = 1'b0;
        endcase
    end

    always_comb begin
        lnk_n = lnk;
        if (op == OP_RSUB) begin
            pc_n = lnk;
        end else if (take) begin
            pc_n = tgt;
        end else begin
            pc_n = pc_seq;
        end
        if (op == OP_JSUB) begin
            lnk_n = pc_seq;
        end
    end

endmodule

// File: rtl/acc_exec_unit.sv
module acc_exec_unit
    import acc_exec_pkg::*;
#(
    parameter int DATA_W = 24,
    parameter int ADDR_W = 20
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              op_vld,
    input  logic [3:0]        op_code,
    input  logic [DATA_W-1:0] acc_in,
    input  logic [DATA_W-1:0] opnd_in,
    input  logic [1:0]        cc_in,
    input  logic [ADDR_W-1:0] lnk_in,
    input  logic [ADDR_W-1:0] pc_in,
    input  logic [ADDR_W-1:0] tgt_in,
    output logic [DATA_W-1:0] acc_q,
    output logic [1:0]        cc_q,
    output logic [ADDR_W-1:0] pc_q,
    output logic [ADDR_W-1:0] lnk_q,
    output logic              div_err,
    output logic              res_valid
);

    op_e               op;
    logic [DATA_W-1:0] arith_res;
    logic              arith_dz;
    cc_e               cmp_cc;
    logic [1:0]        cc_n;
    logic [ADDR_W-1:0] pc_n;
    logic [ADDR_W-1:0] lnk_n;
    state_e            state;
    state_e            state_n;

    assign op = op_e'(op_code);

    acc_arith #(.DATA_W(DATA_W)) arith_i (
        .op       (op),
        .a        (acc_in),
        .b        (opnd_in),
        .res      (arith_res),
        .div_zero (arith_dz)
    );

    acc_compare #(.DATA_W(DATA_W)) cmp_i (
        .a  (acc_in),
        .b  (opnd_in),
        .cc (cmp_cc)
    );

    acc_pc_unit #(.ADDR_W(ADDR_W)) pcu_i (
        .op    (op),
        .cc_in (cc_in),
        .pc    (pc_in),
        .tgt   (tgt_in),
        .lnk   (lnk_in),
        .pc_n  (pc_n),
        .lnk_n (lnk_n)
    );

    assign cc_n = (op == OP_COMP) ? cmp_cc : cc_in;

    // Next-state logic.
    always_comb begin
        state_n = state;
        unique case (state)
            ST_IDLE:   state_n = op_vld ? ST_RESULT : ST_IDLE;
            ST_RESULT: state_n = op_vld ? ST_RESULT : ST_IDLE;
            default:   state_n = ST_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= state_n;
        end
    end

    assign res_valid = (state == ST_RESULT);

    // Result registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_q   <= '0;
            cc_q    <= CC_EQ;
            pc_q    <= '0;
            lnk_q   <= '0;
            div_err <= 1'b0;
        end else if (op_vld) begin
            acc_q   <= arith_res;
            cc_q    <= cc_n;
            pc_q    <= pc_n;
            lnk_q   <= lnk_n;
            div_err <= arith_dz;
        end
    end

endmodule

// File: rtl/acc_exec_unit_chk.sv
module acc_exec_unit_chk
    import acc_exec_pkg::*;
#(
    parameter int DATA_W = 24,
    parameter int ADDR_W = 20
) (
    input logic              clk,
    input logic              rst_n,
    input logic              op_vld,
    input logic [3:0]        op_code,
    input logic [DATA_W-1:0] acc_in,
    input logic [DATA_W-1:0] opnd_in,
    input logic [ADDR_W-1:0] lnk_in,
    input logic [ADDR_W-1:0] pc_in,
    input logic [ADDR_W-1:0] tgt_in,
    input logic [DATA_W-1:0] acc_q,
    input logic [1:0]        cc_q,
    input logic [ADDR_W-1:0] pc_q,
    input logic [ADDR_W-1:0] lnk_q,
    input logic              div_err,
    input logic              res_valid
);

    // R1
    valid_follows_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        op_vld |=> res_valid);

    // R1
    hold_without_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !op_vld |=> (!res_valid && $stable(acc_q) && $stable(pc_q) && $stable(lnk_q) && $stable(cc_q)));

    // R5
    div_zero_keeps_acc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_vld && op_code == OP_DIV && opnd_in == '0) |=> (div_err && acc_q == $past(acc_in)));

    // R6
    comp_keeps_acc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_vld && op_code == OP_COMP) |=> (acc_q == $past(acc_in) && !div_err));

    // R6
    cc_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cc_q != 2'b11 || $past(cc_q) == 2'b11 || res_valid);

    // R8
    call_links_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_vld && op_code == OP_JSUB) |=> (pc_q == $past(tgt_in) && lnk_q == $past(pc_in) + ADDR_W'(3)));

    // R9
    return_jumps_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_vld && op_code == OP_RSUB) |=> (pc_q == $past(lnk_in) && lnk_q == $past(lnk_in)));

endmodule

bind acc_exec_unit acc_exec_unit_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .op_vld    (op_vld),
    .op_code   (op_code),
    .acc_in    (acc_in),
    .opnd_in   (opnd_in),
    .lnk_in    (lnk_in),
    .pc_in     (pc_in),
    .tgt_in    (tgt_in),
    .acc_q     (acc_q),
    .cc_q      (cc_q),
    .pc_q      (pc_q),
    .lnk_q     (lnk_q),
    .div_err   (div_err),
    .res_valid (res_valid)
);

// File: tb/acc_exec_unit_tb.sv
module acc_exec_unit_tb_top;
    import acc_exec_pkg::*;

    localparam int  DATA_W   = 24;
    localparam int  ADDR_W   = 20;
    localparam time CLK_PER  = 10ns;
    localparam int  WD_LIMIT = 20000;

    localparam longint DMASK = (64'd1 << DATA_W) - 1;
    localparam longint AMASK = (64'd1 << ADDR_W) - 1;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              op_vld = 1'b0;
    logic [3:0]        op_code = '0;
    logic [DATA_W-1:0] acc_in = '0;
    logic [DATA_W-1:0] opnd_in = '0;
    logic [1:0]        cc_in = 2'b01;
    logic [ADDR_W-1:0] lnk_in = '0;
    logic [ADDR_W-1:0] pc_in = '0;
    logic [ADDR_W-1:0] tgt_in = '0;
    logic [DATA_W-1:0] acc_q;
    logic [1:0]        cc_q;
    logic [ADDR_W-1:0] pc_q;
    logic [ADDR_W-1:0] lnk_q;
    logic              div_err;
    logic              res_valid;

    int n_checks = 0;
    int n_errors = 0;
    bit finished = 1'b0;

    always #(CLK_PER / 2) clk = ~clk;

    acc_exec_unit #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) dut_i (
        .clk(clk), .rst_n(rst_n), .op_vld(op_vld), .op_code(op_code),
        .acc_in(acc_in), .opnd_in(opnd_in), .cc_in(cc_in), .lnk_in(lnk_in),
        .pc_in(pc_in), .tgt_in(tgt_in), .acc_q(acc_q), .cc_q(cc_q),
        .pc_q(pc_q), .lnk_q(lnk_q), .div_err(div_err), .res_valid(res_valid)
    );

    function automatic longint sx(input longint v);
        return (v & (64'd1 << (DATA_W - 1))) != 0 ? (v | ~DMASK) : (v & DMASK);
    endfunction

    task automatic check(input string tag, input longint act, input longint exp);
        n_checks++;
        if (act != exp) begin
            n_errors++;
            $display("FAIL %s: actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    // Apply one strobed operation and wait until its result is presented.
    task automatic issue(input logic [3:0] oc, input longint a, input longint b,
                         input logic [1:0] cc, input longint lnk, input longint pc,
                         input longint tgt);
        op_code = oc;
        acc_in  = DATA_W'(a & DMASK);
        opnd_in = DATA_W'(b & DMASK);
        cc_in   = cc;
        lnk_in  = ADDR_W'(lnk & AMASK);
        pc_in   = ADDR_W'(pc & AMASK);
        tgt_in  = ADDR_W'(tgt & AMASK);
        op_vld  = 1'b1;
        @(negedge clk);
        op_vld  = 1'b0;
    endtask

    task automatic t_reset;
        check("R10 acc", acc_q, 0);
        check("R10 cc", cc_q, 1);
        check("R10 pc", pc_q, 0);
        check("R10 lnk", lnk_q, 0);
        check("R10 err", div_err, 0);
        check("R10 valid", res_valid, 0);
    endtask

    task automatic t_addsub(input longint a, input longint b);
        issue(OP_ADD, a, b, 2'b10, 64'h1234, 64'h100, 64'h0);
        check("R1 valid", res_valid, 1);
        check("R2 add", acc_q, (a + b) & DMASK);
        check("R2 cc pass", cc_q, 2);
        check("R2 lnk pass", lnk_q, 64'h1234);
        check("R2 pc+3", pc_q, 64'h103);
        issue(OP_SUB, a, b, 2'b00, 64'h55, 64'h200, 64'h0);
        check("R2 sub", acc_q, (a - b) & DMASK);
        check("R2 sub cc pass", cc_q, 0);
    endtask

    task automatic t_mul(input longint a, input longint b);
        issue(OP_MUL, a, b, 2'b01, 0, 0, 0);
        check("R3 mul", acc_q, (sx(a) * sx(b)) & DMASK);
    endtask

    task automatic t_div(input longint a, input longint b);
        issue(OP_DIV, a, b, 2'b01, 0, 0, 0);
        check("R4 div", acc_q, (sx(a) / sx(b)) & DMASK);
        check("R4 no err", div_err, 0);
    endtask

    task automatic t_div_zero;
        issue(OP_DIV, 64'h345678, 0, 2'b01, 0, 0, 0);
        check("R5 acc kept", acc_q, 64'h345678);
        check("R5 err set", div_err, 1);
        issue(OP_ADD, 1, 1, 2'b01, 0, 0, 0);
        check("R5 err cleared", div_err, 0);
    endtask

    task automatic t_comp(input longint a, input longint b, input longint exp_cc);
        issue(OP_COMP, a, b, 2'b01, 0, 0, 0);
        check("R6 cc", cc_q, exp_cc);
        check("R6 acc kept", acc_q, a & DMASK);
    endtask

    task automatic t_jumps;
        logic [3:0] ops [3];
        ops[0] = OP_JLT; ops[1] = OP_JEQ; ops[2] = OP_JGT;
        for (int j = 0; j < 3; j++) begin
            for (int c = 0; c < 3; c++) begin
                issue(ops[j], 0, 0, 2'(c), 0, 64'h400, 64'h8888);
                check("R7 jump pc", pc_q, (j == c) ? 64'h8888 : 64'h403);
            end
        end
        issue(OP_JEQ, 0, 0, 2'b00, 0, 64'hFFFFE, 64'h1);
        check("R7 pc wrap", pc_q, 64'h1);
    endtask

    task automatic t_call_ret;
        issue(OP_JSUB, 0, 0, 2'b01, 64'h777, 64'hFFFFF, 64'h2000);
        check("R8 pc", pc_q, 64'h2000);
        check("R8 lnk", lnk_q, 64'h2);
        issue(OP_RSUB, 0, 0, 2'b01, 64'h3003, 64'h2010, 64'h9999);
        check("R9 pc", pc_q, 64'h3003);
        check("R9 lnk", lnk_q, 64'h3003);
    endtask

    task automatic t_undef;
        issue(OP_DIV, 5, 0, 2'b01, 0, 0, 0);
        issue(4'd12, 64'hABCDEF, 64'h1, 2'b10, 64'h444, 64'h10, 64'h50);
        check("R11 acc", acc_q, 64'hABCDEF);
        check("R11 cc", cc_q, 2);
        check("R11 lnk", lnk_q, 64'h444);
        check("R11 pc", pc_q, 64'h13);
        check("R11 err", div_err, 0);
    endtask

    task automatic t_hold;
        issue(OP_ADD, 64'h10, 64'h20, 2'b01, 64'h5, 64'h60, 0);
        op_code = OP_SUB; acc_in = 24'hFFFFFF; opnd_in = 24'h1; pc_in = 20'h7;
        lnk_in = 20'h9;
        @(negedge clk);
        check("R1 valid low", res_valid, 0);
        @(negedge clk);
        @(negedge clk);
        check("R1 acc held", acc_q, 64'h30);
        check("R1 pc held", pc_q, 64'h63);
        check("R1 lnk held", lnk_q, 64'h5);
    endtask

    initial begin
        repeat (WD_LIMIT) @(posedge clk);
        if (!finished) begin
            n_errors++;
            n_checks++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_addsub(64'h000005, 64'h000003);
        t_addsub(64'hFFFFFF, 64'h000001);
        t_addsub(64'h800000, 64'h7FFFFF);
        t_mul(64'h000007, 64'hFFFFFD);
        t_mul(64'h123456, 64'h000100);
        t_mul(64'h800000, 64'hFFFFFF);
        t_div(64'hFFFFF9, 64'h000002);
        t_div(64'h000007, 64'hFFFFFE);
        t_div(64'h800000, 64'hFFFFFF);
        t_div(64'h000064, 64'h000007);
        t_div_zero();
        t_comp(64'hFFFFFF, 64'h000001, 0);
        t_comp(64'h000001, 64'hFFFFFF, 2);
        t_comp(64'h123456, 64'h123456, 1);
        t_comp(64'h800000, 64'h7FFFFF, 0);
        t_jumps();
        t_call_ret();
        t_undef();
        t_hold();
        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

endmodule